// File: doc/BRIEF.md
# Reset Cause and Software Reset Request Register

This block holds a single 32-bit word that tells firmware why the chip last came out of reset. The same word lets firmware ask for a new reset. Only the five most significant bits carry meaning. Bits 31, 28 and 27 are cause flags that firmware clears by writing a 1 to them. Bits 30 and 29 are request bits that firmware sets by writing a 1 to them. Writing a 1 to either request bit produces a one-cycle pulse on `reset_req_o`, which the chip's reset controller consumes.

The block tells the first system reset after power-up apart from later ones by means of a small saturating reset counter. The counter is cleared by the raw power-up input `por_n`. It is also cleared by a software request on bit 30, which asks for a power-on-class reset. Each system reset event is signalled on `rst_evt_i`. An event that finds the counter at zero loads the word with only bit 31 set. An event that finds the counter nonzero leaves the word as it was. In both cases the counter then advances.

The word sits in the upper 32-bit half (byte offset 4) of an 8-byte slot. The lower half reads as zero and takes no writes. The request pulse comes from a two-state machine:
- State `REQ_IDLE` moves to `REQ_PULSE` on a request write (transition *fire*).
- State `REQ_PULSE` returns to `REQ_IDLE` (transition *expire*), unless another request write arrives in that cycle (transition *refire*).

Top module: `rst_status_ctl`

## Requirements
- R1: Bits 26:0 always read as zero, and writes to them have no effect.
- R2: When address bit 2 is 0 (the lower word), the read data is zero. A write there changes nothing and raises no request.
- R3: Writing a 1 to bit 31, 28 or 27 clears that bit. Writing 0 leaves it unchanged. No write can set these bits.
- R4: Writing a 1 to bit 30 or 29 sets that bit. Writing 0 leaves it unchanged.
- R5: A write to the upper word with bit 30 or bit 29 equal to 1 drives `reset_req_o` high for exactly the cycle after the write's clock edge.
- R6: A write with bit 30 equal to 1 clears the reset counter. The next reset event therefore loads the word with 0x80000000.
- R7: A write with bit 29 equal to 1 and bit 30 equal to 0 leaves the counter unchanged.
- R8: After `por_n` is released, the first reset event loads the word with 0x80000000 exactly.
- R9: A reset event that finds the counter nonzero leaves the word unchanged.
- R10: When a reset event and a write fall in the same cycle, the reset event is applied and the write is discarded. This means no bit change, no counter clear and no request pulse.
- R11: While `por_n` is low and right after its release, the word reads zero and `reset_req_o` is low.
- R12: The counter saturates at its maximum value. However many reset events follow, it never wraps back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-up reset; clears the word and the counter |
| rst_evt_i | input | 1 | One-cycle strobe marking a system reset event |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte offset within the 8-byte slot; bit 2 selects the upper word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word selected by `addr_i` |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
A reset event and a register write can arrive in the same cycle. In that case the reset handling must win, and the write must leave no trace. The bench provokes this by asserting `rst_evt_i` together with a write that sets bit 30. It then checks three things: the word is unchanged, no request pulse follows, and a later reset event still finds the counter nonzero. That last point shows that the dropped write did not clear the counter. The same-cycle case is also checked against the property that no pulse ever follows a reset event.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int DATA_W    = 32;
    localparam int FIELD_LO  = 27;
    localparam int WORD_SEL  = 2;
    localparam int BIT_PWRON = 31;
    localparam int BIT_SWPOR = 30;
    localparam int BIT_SWXIR = 29;

    localparam logic [DATA_W-1:0] LIVE_MASK = 32'hF800_0000;
    localparam logic [DATA_W-1:0] W1C_MASK  = 32'h9800_0000;
    localparam logic [DATA_W-1:0] W1S_MASK  = 32'h6000_0000;
    localparam logic [DATA_W-1:0] PWRON_VAL = 32'h8000_0000;

    typedef enum logic {
        REQ_IDLE  = 1'b0,
        REQ_PULSE = 1'b1
    } req_state_t;
endpackage

// File: rtl/rsc_count.sv
module rsc_count #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (evt_i) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (clr_i) begin
            cnt_q <= '0;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rsc_bits.sv
module rsc_bits
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              evt_i,
    input  logic              load_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wval_i,
    output logic [DATA_W-1:0] q_o
);
    assign q_o[FIELD_LO-1:0] = '0;

    for (genvar i = FIELD_LO; i < DATA_W; i++) begin : g_bit
        logic bit_q;
        logic bit_d;

        if (W1C_MASK[i]) begin : g_w1c
            always_comb begin
                bit_d = bit_q;
                if (evt_i) begin
                    if (load_i) bit_d = PWRON_VAL[i];
                end else if (wr_i && wval_i[i]) begin
                    bit_d = 1'b0;
                end
            end
        end else begin : g_w1s
            always_comb begin
                bit_d = bit_q;
                if (evt_i) begin
                    if (load_i) bit_d = PWRON_VAL[i];
                end else if (wr_i && wval_i[i]) begin
                    bit_d = 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign q_o[i] = bit_q;
    end
endmodule

// File: rtl/rsc_req_fsm.sv
module rsc_req_fsm
    import rsc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic fire_i,
    output logic req_o
);
    req_state_t state_q;
    req_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:  if (fire_i) state_d = REQ_PULSE;
            REQ_PULSE: state_d = fire_i ? REQ_PULSE : REQ_IDLE;
            default:   state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            REQ_PULSE: req_o = 1'b1;
            default:   req_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rst_status_ctl.sv
module rst_status_ctl
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              reset_req_o
);
    logic              upper_sel;
    logic              wr_take;
    logic [DATA_W-1:0] wval;
    logic              cnt_zero;
    logic              req_fire;
    logic [DATA_W-1:0] status_q;

    assign upper_sel = addr_i[WORD_SEL];
    assign wr_take   = wr_en_i && upper_sel && !rst_evt_i;
    assign wval      = wdata_i & LIVE_MASK;
    assign req_fire  = wr_take && (wval[BIT_SWPOR] || wval[BIT_SWXIR]);

    rsc_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .por_n  (por_n),
        .evt_i  (rst_evt_i),
        .clr_i  (wr_take && wval[BIT_SWPOR]),
        .zero_o (cnt_zero)
    );

    rsc_bits u_bits (
        .clk    (clk),
        .por_n  (por_n),
        .evt_i  (rst_evt_i),
        .load_i (cnt_zero),
        .wr_i   (wr_take),
        .wval_i (wval),
        .q_o    (status_q)
    );

    rsc_req_fsm u_req (
        .clk    (clk),
        .por_n  (por_n),
        .fire_i (req_fire),
        .req_o  (reset_req_o)
    );

    assign rdata_o = upper_sel ? status_q : '0;
endmodule

// File: rtl/rst_status_ctl_chk.sv
module rst_status_ctl_chk
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_evt_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              reset_req_o,
    input logic [DATA_W-1:0] status_q
);
    logic wr_up;
    assign wr_up = wr_en_i && addr_i[WORD_SEL] && !rst_evt_i;

    assert_low_zero_R1: assert property (@(posedge clk) disable iff (!por_n)
        rdata_o[FIELD_LO-1:0] == '0);

    assert_even_zero_R2: assert property (@(posedge clk) disable iff (!por_n)
        !addr_i[WORD_SEL] |-> rdata_o == '0);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!por_n)
        (wr_up && wdata_i[BIT_PWRON]) |=> !status_q[BIT_PWRON]);

    assert_set_R4: assert property (@(posedge clk) disable iff (!por_n)
        (wr_up && wdata_i[BIT_SWXIR]) |=> status_q[BIT_SWXIR]);

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!por_n)
        (wr_up && (wdata_i[BIT_SWPOR] || wdata_i[BIT_SWXIR])) |=> reset_req_o);

    assert_quiet_R5: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_up && (wdata_i[BIT_SWPOR] || wdata_i[BIT_SWXIR])) |=> !reset_req_o);

    assert_evt_R9: assert property (@(posedge clk) disable iff (!por_n)
        rst_evt_i |=> (status_q == PWRON_VAL || status_q == $past(status_q)));

    assert_evt_wins_R10: assert property (@(posedge clk) disable iff (!por_n)
        rst_evt_i |=> !reset_req_o);
endmodule

bind rst_status_ctl rst_status_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_evt_i   (rst_evt_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .reset_req_o (reset_req_o),
    .status_q    (status_q)
);

// File: tb/rst_status_ctl_test.sv
module rst_status_ctl_test;
    localparam int CNT_MAX = 15;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_evt_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd4;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        reset_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] q_rd[$];
    logic        q_req[$];
    string       q_tag[$];

    logic [31:0] m_reg = '0;
    int          m_cnt = 0;

    always #4 clk = ~clk;

    rst_status_ctl uut (
        .clk(clk), .por_n(por_n), .rst_evt_i(rst_evt_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .reset_req_o(reset_req_o)
    );

    always @(posedge clk) begin
        #2;
        if (q_rd.size() > 0) begin
            logic [31:0] er;
            logic        eq;
            string       tg;
            er = q_rd.pop_front();
            eq = q_req.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (rdata_o !== er || reset_req_o !== eq) begin
                errors++;
                $display("FAIL %s: rdata=%h req=%b expected rdata=%h req=%b",
                         tg, rdata_o, reset_req_o, er, eq);
            end
        end
    end

    task automatic step(input bit wr, input logic [2:0] a, input logic [31:0] d,
                        input bit ev, input string tag);
        logic [31:0] v;
        bit fire;
        bit req;
        @(negedge clk);
        wr_en_i = wr; addr_i = a; wdata_i = d; rst_evt_i = ev;
        v    = d & 32'hF800_0000;
        fire = wr && a[2] && !ev;
        req  = fire && (v[30] || v[29]);
        if (ev) begin
            if (m_cnt == 0) m_reg = 32'h8000_0000;
            if (m_cnt < CNT_MAX) m_cnt++;
        end else if (fire) begin
            m_reg = (m_reg & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
            if (v[30]) m_cnt = 0;
        end
        q_rd.push_back(a[2] ? m_reg : 32'h0);
        q_req.push_back(req);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd4, 32'h0, 1'b0, tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rdata_o !== 32'h0 || reset_req_o !== 1'b0) begin
            errors++;
            $display("FAIL R11: rdata=%h req=%b expected rdata=%h req=0", rdata_o, reset_req_o, 32'h0);
        end
        por_n = 1'b1;
        idle("R11");
        step(1'b0, 3'd4, 32'h0, 1'b1, "R8");
        step(1'b1, 3'd4, 32'h2000_0000, 1'b0, "R4 R5");
        idle("R5");
        step(1'b0, 3'd4, 32'h0, 1'b1, "R7 R9");
        step(1'b1, 3'd4, 32'h8000_0000, 1'b0, "R3");
        step(1'b1, 3'd4, 32'h1800_0000, 1'b0, "R3");
        step(1'b1, 3'd4, 32'h0000_0000, 1'b0, "R4");
        step(1'b1, 3'd4, 32'h07FF_FFFF, 1'b0, "R1");
        step(1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, "R2");
        idle("R2");
        step(1'b1, 3'd4, 32'h4000_0000, 1'b0, "R6 R5");
        step(1'b0, 3'd4, 32'h0, 1'b1, "R6");
        step(1'b1, 3'd4, 32'h4000_0000, 1'b1, "R10");
        idle("R10");
        step(1'b0, 3'd4, 32'h0, 1'b1, "R10");
        step(1'b1, 3'd4, 32'h2000_0000, 1'b0, "R12");
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 3'd4, 32'h0, 1'b1, "R12");
        end
        step(1'b1, 3'd4, 32'h4000_0000, 1'b0, "R5 R6");
        step(1'b1, 3'd4, 32'h4000_0000, 1'b0, "R5");
        idle("R5");
        step(1'b0, 3'd4, 32'h0, 1'b1, "R6 R8");
        idle("R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule